// File: doc/BRIEF.md
# PCI Target Termination Signaller

This block is the part of a PCI target that decides how a claimed transaction ends and drives the three target-side handshake lines for it. Once address decode reports a hit during an address phase, the block asserts device-select and then lets the local backend pace the data phases through a ready input. At any point the backend may ask to stop. It can ask for a disconnect, because it cannot continue the burst. It can ask for a retry, because it cannot take the transaction now. It can ask for an abort, because of a fatal error.

The block turns each request into the matching stop, target-ready and device-select pattern. It keeps that pattern steady until the master finishes. When the request does not fit the history of the transaction, the block corrects it. A retry after data has moved becomes a disconnect, and a disconnect that would move no data becomes a retry. The block also counts the data phases that complete while stop is asserted, and it sets the signalled-abort bit of the target status word.

All bus lines are shown as active-high "asserted" levels. The inversion to the low-true bus pins and the tri-state drivers sit outside this block. Reset is synchronous and active-high. Every output is registered.

Top module: `pci_tgt_term`

## Requirements
- R1: While reset is high, at the following clock edge stop, target-ready, device-select, the termination kind, the stop-phase count and the status word all become zero.
- R2: When idle, a clock edge with both frame and hit asserted claims the transaction. From the next cycle device-select is 1 and stop and target-ready are 0. Hit without frame claims nothing.
- R3: While claimed and not stopping, target-ready equals the ready input of the previous edge. The edge that sees frame negated with initiator-ready and target-ready both asserted completes the last phase. From the next cycle all three bus outputs are 0.
- R4: A retry request before any data phase has completed gives stop=1, target-ready=0, device-select=1 and kind 2 from the next cycle.
- R5: A retry request after at least one data phase has completed is signalled as a disconnect. That means kind 1, stop=1, device-select=1, and target-ready equal to ready. A phase completing on the same edge counts as completed.
- R6: A disconnect gives stop=1, device-select=1 and kind 1, with target-ready taken from ready. While stop is held, once target-ready is 0 it stays 0 until release.
- R7: An abort request gives stop=1, device-select=0, target-ready=0 and kind 3 from the next cycle. Device-select was 1 in the cycle before.
- R8: Once stop is 1, it stays 1 until an edge sees frame negated with initiator-ready asserted. After that edge, stop, target-ready, device-select and kind are all 0 together.
- R9: The status word is 16 bits wide. Bit 11 becomes 1 in the same cycle that stop first appears for an abort, and it stays 1 until reset. All other status bits are always 0.
- R10: The count output is cleared when a transaction is claimed. It then increments once for each edge with stop, target-ready and initiator-ready all asserted. It saturates at all ones, which is 15 for 4 bits.
- R11: Abort takes priority over retry and disconnect. A normal last-phase completion takes priority over any request on the same edge. Requests are ignored when no transaction is claimed.
- R12: A disconnect request with no data phase completed and ready low is signalled as a retry (kind 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Master frame asserted |
| irdy_i | input | 1 | Initiator ready asserted |
| hit_i | input | 1 | Address decode hit for this target |
| ready_i | input | 1 | Backend can transfer a data phase |
| req_disc_i | input | 1 | Backend asks to disconnect |
| req_retry_i | input | 1 | Backend asks to retry |
| req_abort_i | input | 1 | Backend asks to abort |
| stop_o | output | 1 | Stop asserted |
| trdy_o | output | 1 | Target ready asserted |
| devsel_o | output | 1 | Device select asserted |
| kind_o | output | 2 | Active termination: 0 none, 1 disconnect, 2 retry, 3 abort |
| cnt_o | output | CNT_W | Data phases completed while stop was asserted |
| sta_o | output | 16 | Target status word, bit 11 = signalled abort |

## Verification
Several patterns are applied. A plain burst with a wait state shows that ready is followed and that the last phase is released. Retry and disconnect requests are each applied before and after the first completed phase, which separates the two conversions from plain pass-through. A disconnect that keeps ready high for many phases, with the master holding frame, tests the stop-phase counter and its saturation. It also tests that target-ready cannot return once dropped. Simultaneous requests, and a request on the same edge as the final phase, show the priority order. Requests while idle show that they are ignored.

// File: rtl/pci_tgt_term_pkg.sv
package pci_tgt_term_pkg;

  // Termination kind as presented on kind_o
  typedef enum logic [1:0] {
    TK_NONE  = 2'd0,
    TK_DISC  = 2'd1,
    TK_RETRY = 2'd2,
    TK_ABORT = 2'd3
  } term_kind_e;

  // Target-side transaction phase
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CLAIM = 2'd1,
    PH_HOLD  = 2'd2
  } phase_e;

endpackage

// File: rtl/term_resolve.sv
module term_resolve
  import pci_tgt_term_pkg::*;
(
  input  logic       req_disc_i,
  input  logic       req_retry_i,
  input  logic       req_abort_i,
  input  logic       moved_i,
  input  logic       ready_i,
  output term_kind_e kind_o
);

  logic any_soft;
  logic keep_data;

  assign any_soft  = req_disc_i | req_retry_i;
  // data already moved, or about to move with stop: must be a disconnect
  assign keep_data = moved_i | (req_disc_i & ready_i);

  always_comb begin
    if (req_abort_i)   kind_o = TK_ABORT;
    else if (any_soft) kind_o = keep_data ? TK_DISC : TK_RETRY;
    else               kind_o = TK_NONE;
  end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pci_tgt_term.sv
module pci_tgt_term
  import pci_tgt_term_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int STS_W   = 16,
  parameter int STA_BIT = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_i,
  input  logic             irdy_i,
  input  logic             hit_i,
  input  logic             ready_i,
  input  logic             req_disc_i,
  input  logic             req_retry_i,
  input  logic             req_abort_i,
  output logic             stop_o,
  output logic             trdy_o,
  output logic             devsel_o,
  output logic [1:0]       kind_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [STS_W-1:0] sta_o
);

  phase_e     ph_q, ph_d;
  term_kind_e kind_q, kind_d, res_kind;
  logic       stop_q, stop_d;
  logic       trdy_q, trdy_d;
  logic       dev_q, dev_d;
  logic       moved_q, moved_d;
  logic       sta_q, sta_d;

  logic xfer, stop_xfer, moved_now;
  logic claim, release_norm, release_hold;

  assign xfer         = trdy_q & irdy_i;
  assign stop_xfer    = stop_q & xfer;
  assign moved_now    = moved_q | xfer;
  assign claim        = (ph_q == PH_IDLE) & frame_i & hit_i;
  assign release_norm = (ph_q == PH_CLAIM) & ~frame_i & irdy_i & trdy_q;
  assign release_hold = (ph_q == PH_HOLD) & ~frame_i & irdy_i;

  term_resolve u_res (
    .req_disc_i  (req_disc_i),
    .req_retry_i (req_retry_i),
    .req_abort_i (req_abort_i),
    .moved_i     (moved_now),
    .ready_i     (ready_i),
    .kind_o      (res_kind)
  );

  always_comb begin
    ph_d    = ph_q;
    kind_d  = kind_q;
    stop_d  = stop_q;
    trdy_d  = trdy_q;
    dev_d   = dev_q;
    moved_d = moved_q;
    sta_d   = sta_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (claim) begin
          ph_d    = PH_CLAIM;
          dev_d   = 1'b1;
          trdy_d  = 1'b0;
          moved_d = 1'b0;
        end
      end
      PH_CLAIM: begin
        moved_d = moved_now;
        if (release_norm) begin
          ph_d   = PH_IDLE;
          dev_d  = 1'b0;
          trdy_d = 1'b0;
        end else if (res_kind != TK_NONE) begin
          ph_d   = PH_HOLD;
          stop_d = 1'b1;
          kind_d = res_kind;
          dev_d  = (res_kind != TK_ABORT);
          trdy_d = (res_kind == TK_DISC) & ready_i;
          if (res_kind == TK_ABORT) sta_d = 1'b1;
        end else begin
          trdy_d = ready_i;
        end
      end
      PH_HOLD: begin
        if (release_hold) begin
          ph_d   = PH_IDLE;
          stop_d = 1'b0;
          trdy_d = 1'b0;
          dev_d  = 1'b0;
          kind_d = TK_NONE;
        end else begin
          // once target-ready drops under stop it never returns
          trdy_d = trdy_q & ready_i;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      kind_q  <= TK_NONE;
      stop_q  <= 1'b0;
      trdy_q  <= 1'b0;
      dev_q   <= 1'b0;
      moved_q <= 1'b0;
      sta_q   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      kind_q  <= kind_d;
      stop_q  <= stop_d;
      trdy_q  <= trdy_d;
      dev_q   <= dev_d;
      moved_q <= moved_d;
      sta_q   <= sta_d;
    end
  end

  sat_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr_i (claim),
    .inc_i (stop_xfer),
    .cnt_o (cnt_o)
  );

  assign stop_o   = stop_q;
  assign trdy_o   = trdy_q;
  assign devsel_o = dev_q;
  assign kind_o   = kind_q;
  assign sta_o    = STS_W'(sta_q) << STA_BIT;

endmodule

// File: rtl/pci_tgt_term_chk.sv
module pci_tgt_term_chk #(
  parameter int CNT_W   = 4,
  parameter int STS_W   = 16,
  parameter int STA_BIT = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_i,
  input logic             irdy_i,
  input logic             stop_o,
  input logic             trdy_o,
  input logic             devsel_o,
  input logic [1:0]       kind_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic [STS_W-1:0] sta_o
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  a_r8_stop_held: assert property (@(posedge clk) disable iff (rst)
    stop_o && !(!frame_i && irdy_i) |=> stop_o);

  a_r8_release_together: assert property (@(posedge clk) disable iff (rst)
    stop_o && !frame_i && irdy_i |=> !stop_o && !trdy_o && !devsel_o && kind_o == 2'd0);

  a_r7_abort_shape: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_o) && kind_o == 2'd3 |-> !devsel_o && !trdy_o && $past(devsel_o));

  a_r4_retry_shape: assert property (@(posedge clk) disable iff (rst)
    stop_o && kind_o == 2'd2 |-> !trdy_o && devsel_o);

  a_r6_trdy_no_return: assert property (@(posedge clk) disable iff (rst)
    stop_o && !trdy_o |=> !trdy_o);

  a_r9_sta_sticky: assert property (@(posedge clk) disable iff (rst)
    sta_o[STA_BIT] |=> sta_o[STA_BIT]);

  a_r9_sta_on_abort: assert property (@(posedge clk) disable iff (rst)
    $rose(sta_o[STA_BIT]) |-> stop_o && kind_o == 2'd3);

  a_r10_cnt_step: assert property (@(posedge clk) disable iff (rst)
    stop_o && trdy_o && irdy_i && cnt_o != CMAX |=> cnt_o == $past(cnt_o) + 1'b1);

endmodule

bind pci_tgt_term pci_tgt_term_chk #(
  .CNT_W(CNT_W), .STS_W(STS_W), .STA_BIT(STA_BIT)
) u_chk (
  .clk(clk), .rst(rst), .frame_i(frame_i), .irdy_i(irdy_i),
  .stop_o(stop_o), .trdy_o(trdy_o), .devsel_o(devsel_o),
  .kind_o(kind_o), .cnt_o(cnt_o), .sta_o(sta_o)
);

// File: tb/pci_tgt_term_bench.sv
`timescale 1ns/1ps
module pci_tgt_term_bench;

  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame = 0, irdy = 0, hit = 0, rdy = 0, ds = 0, rt = 0, ab = 0;
  logic             stop_o, trdy_o, devsel_o;
  logic [1:0]       kind_o;
  logic [CNT_W-1:0] cnt_o;
  logic [15:0]      sta_o;

  always #2 clk = ~clk;

  pci_tgt_term #(.CNT_W(CNT_W)) u_pci_tgt_term (
    .clk(clk), .rst(rst), .frame_i(frame), .irdy_i(irdy), .hit_i(hit),
    .ready_i(rdy), .req_disc_i(ds), .req_retry_i(rt), .req_abort_i(ab),
    .stop_o(stop_o), .trdy_o(trdy_o), .devsel_o(devsel_o),
    .kind_o(kind_o), .cnt_o(cnt_o), .sta_o(sta_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // behavioural reference: 0 idle, 1 claimed, 2 stopping
  int m_st = 0, m_kind = 0, m_cnt = 0;
  bit m_stop = 0, m_trdy = 0, m_dev = 0, m_sta = 0, m_moved = 0;

  always @(posedge clk) begin : ref_model
    bit xf, sx, mv;
    int k;
    if (rst) begin
      m_st = 0; m_kind = 0; m_cnt = 0;
      m_stop = 0; m_trdy = 0; m_dev = 0; m_sta = 0; m_moved = 0;
    end else begin
      xf = m_trdy && irdy;
      sx = m_stop && xf;
      if (m_st == 0) begin
        if (frame && hit) begin
          m_st = 1; m_dev = 1; m_trdy = 0; m_cnt = 0; m_moved = 0;
        end
      end else if (m_st == 1) begin
        mv = m_moved || xf;
        if (!frame && irdy && m_trdy) begin
          m_st = 0; m_dev = 0; m_trdy = 0;
        end else if (ab) begin
          m_st = 2; m_stop = 1; m_dev = 0; m_trdy = 0; m_kind = 3; m_sta = 1;
        end else if (rt || ds) begin
          k = (mv || (ds && rdy)) ? 1 : 2;
          m_st = 2; m_stop = 1; m_kind = k; m_trdy = (k == 1) && rdy;
        end else begin
          m_trdy = rdy;
        end
        m_moved = mv;
      end else begin
        if (sx && m_cnt < CMAX) m_cnt++;
        if (!frame && irdy) begin
          m_st = 0; m_stop = 0; m_trdy = 0; m_dev = 0; m_kind = 0;
        end else begin
          m_trdy = m_trdy && rdy;
        end
      end
    end
  end

  task automatic chk(input string r, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(cur_req, "stop",   int'(stop_o),   int'(m_stop));
    chk(cur_req, "trdy",   int'(trdy_o),   int'(m_trdy));
    chk(cur_req, "devsel", int'(devsel_o), int'(m_dev));
    chk(cur_req, "kind",   int'(kind_o),   m_kind);
    chk("R9",  "status", int'(sta_o), m_sta ? 2048 : 0);
    chk("R10", "count",  int'(cnt_o), m_cnt);
  endtask

  task automatic cyc(input bit f, input bit i, input bit h, input bit r,
                     input bit d, input bit t, input bit a, input string tag);
    frame = f; irdy = i; hit = h; rdy = r; ds = d; rt = t; ab = a;
    cur_req = tag;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic claim_it(input string tag);
    cyc(1, 0, 1, 0, 0, 0, 0, tag);
  endtask

  task automatic idle_it(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    cur_req = "R1";
    compare_all();
    rst = 1'b0;
    idle_it("R1");

    // R2 hit without frame does not claim
    cyc(0, 0, 1, 0, 0, 0, 0, "R2");
    // R2 R3 plain burst with a wait state
    claim_it("R2");
    cyc(1, 1, 0, 1, 0, 0, 0, "R3");
    cyc(1, 1, 0, 0, 0, 0, 0, "R3");
    cyc(1, 1, 0, 1, 0, 0, 0, "R3");
    cyc(0, 1, 0, 1, 0, 0, 0, "R3");
    idle_it("R3");

    // R4 R8 retry before data, master delays release
    claim_it("R4");
    cyc(1, 0, 0, 0, 0, 1, 0, "R4");
    cyc(1, 0, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(0, 1, 0, 0, 0, 0, 0, "R8");
    idle_it("R8");

    // R5 retry after data becomes disconnect
    claim_it("R5");
    cyc(1, 1, 0, 1, 0, 0, 0, "R5");
    cyc(1, 1, 0, 1, 0, 1, 0, "R5");
    cyc(1, 1, 0, 1, 0, 0, 0, "R5");
    cyc(0, 1, 0, 0, 0, 0, 0, "R5");
    idle_it("R5");

    // R6 disconnect with data, target-ready drops and stays down
    claim_it("R6");
    cyc(1, 0, 0, 1, 1, 0, 0, "R6");
    cyc(1, 1, 0, 1, 0, 0, 0, "R6");
    cyc(1, 1, 0, 0, 0, 0, 0, "R6");
    cyc(1, 1, 0, 1, 0, 0, 0, "R6");
    cyc(1, 1, 0, 1, 0, 0, 0, "R6");
    cyc(0, 1, 0, 1, 0, 0, 0, "R8");
    idle_it("R6");

    // R12 disconnect with nothing moved and not ready
    claim_it("R12");
    cyc(1, 0, 0, 0, 1, 0, 0, "R12");
    cyc(0, 1, 0, 0, 0, 0, 0, "R12");
    idle_it("R12");

    // R7 R9 abort after a data phase
    claim_it("R7");
    cyc(1, 1, 0, 1, 0, 0, 0, "R7");
    cyc(1, 1, 0, 1, 0, 0, 1, "R7");
    cyc(1, 1, 0, 1, 0, 0, 0, "R7");
    cyc(0, 1, 0, 0, 0, 0, 0, "R7");
    idle_it("R9");

    // R11 abort beats retry and disconnect
    claim_it("R11");
    cyc(1, 0, 0, 1, 1, 1, 1, "R11");
    cyc(0, 1, 0, 0, 0, 0, 0, "R11");
    idle_it("R11");
    // R11 last-phase completion beats a request
    claim_it("R11");
    cyc(1, 1, 0, 1, 0, 0, 0, "R11");
    cyc(0, 1, 0, 1, 0, 1, 0, "R11");
    idle_it("R11");
    // R11 requests while idle are ignored
    cyc(0, 0, 0, 1, 1, 1, 1, "R11");
    cyc(0, 1, 0, 1, 1, 1, 1, "R11");

    // R10 long disconnect burst saturates the counter
    claim_it("R10");
    cyc(1, 0, 0, 1, 1, 0, 0, "R10");
    for (int k = 0; k < 18; k++) cyc(1, 1, 0, 1, 0, 0, 0, "R10");
    cyc(0, 1, 0, 1, 0, 0, 0, "R10");
    idle_it("R10");
    // R10 a new claim clears the count
    claim_it("R10");
    cyc(1, 1, 0, 1, 0, 0, 0, "R10");
    cyc(0, 1, 0, 1, 0, 0, 0, "R10");
    idle_it("R10");

    // R1 reset clears the sticky status
    rst = 1'b1;
    idle_it("R1");
    rst = 1'b0;
    idle_it("R1");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule